// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block keeps a parameterised set of error-logging banks for one processor core. Each bank holds four 64-bit registers: control, status, address and misc. Three global registers sit beside them: capability (bank count and a flag saying whether a global control register exists), global control, and global status (which carries the check-in-progress flag). Software reads and writes all of them through a simple indexed register port.

An error source presents one injection per cycle on the inject port. The injection carries a bank number, a status word, a global status word, an address, a misc value and an unconditional flag. In the same cycle the block decides whether to reject the injection, ignore it, suppress it, log it, only mark an overflow in the existing record, or request a reset. On the next clock edge it updates the registers, reports a response code for one cycle and, for a logged uncorrected error, pulses the machine-check interrupt.

A two-state machine times the response. It starts in ST_IDLE. The transition named accept goes from ST_IDLE to ST_REPORT on an injection. In ST_REPORT, a further injection takes the transition named chain and stays in ST_REPORT. With no injection, the transition named drain returns to ST_IDLE. The response is valid exactly while the machine is in ST_REPORT.

Top module: `mce_bank_logger`

## Requirements
- R1: After reset, capability reads {bit 8 = GCTL_PRESENT, bits 7:0 = NBANK}, global control and every bank control read all ones, global status and every bank status, address and misc read zero, and mc_irq, reset_req, resp_valid are low with resp_code 0.
- R2: Register map: address 0 is capability, 1 global control, 2 global status, 3 reads zero. Bank b occupies addresses 4+4b (control), 5+4b (status), 6+4b (address) and 7+4b (misc). Addresses past the last bank read zero. All registers are read/write.
- R3: An injection is rejected (code 1) with no register change when capability is zero, the bank number is at or above capability bits 7:0 or at or above NBANK, or status bit 63 (valid) is clear.
- R4: An injection whose status bit 55 (action required) is clear, arriving while global status bit 2 (in progress) is set and with inj_uncond low, is ignored (code 2) with no register change.
- R5: For an uncorrected error (status bit 61 set), if capability bit 8 is set and global control is not all ones, the error is suppressed (code 3) with no register change. With capability bit 8 clear, global control has no effect.
- R6: For an uncorrected error, a bank control that is not all ones suppresses the error (code 3). It does not affect corrected errors.
- R7: An uncorrected error that is not suppressed raises reset_req for one cycle (code 6), with no register change, when global status bit 2 is already set or mce_en is low.
- R8: Otherwise an uncorrected error is logged (code 4). The block writes the bank address, misc and status, and the global status takes inj_gstatus. The new status is the injected status with bit 62 (overflow) set if the old status had bit 63 set. mc_irq pulses for one cycle.
- R9: A corrected error (bit 61 clear) is logged (code 4) when the old bank status is invalid or not uncorrected. Address, misc and status are overwritten, and bit 62 is set if the old status was valid. Global status is unchanged and there is no interrupt.
- R10: A corrected error that arrives while the bank holds a valid uncorrected record only sets bit 62 of the existing status (code 5).
- R11: resp_valid is high, with a nonzero resp_code, exactly in the cycle after each cycle with inj_valid high, including back-to-back injections.
- R12: When a software write and an injection land in the same cycle, the decision uses register contents from before that edge. An injection update to a register wins over a software write to the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mce_en | input | 1 | Machine-check delivery enabled by the core |
| inj_valid | input | 1 | Injection present this cycle |
| inj_bank | input | 8 | Target bank number |
| inj_status | input | 64 | Status word to log |
| inj_gstatus | input | 64 | Global status to load on uncorrected logging |
| inj_addr | input | 64 | Address value |
| inj_misc | input | 64 | Misc value |
| inj_uncond | input | 1 | Deliver even while a check is in progress |
| reg_we | input | 1 | Software register write strobe |
| reg_addr | input | AW | Register index |
| reg_wdata | input | 64 | Software write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| mc_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Reset request pulse |
| resp_valid | output | 1 | Response code valid |
| resp_code | output | 3 | 1 reject, 2 ignore, 3 suppress, 4 logged, 5 overflow only, 6 reset |

## Verification
A software register write and an injection can fall on the same clock edge. The bench provokes this by driving reg_we and inj_valid in one cycle. In one case both target the same bank's address register, and the injected address must remain. In another case, global control is cleared while an uncorrected error is injected. That error must still be logged because its decision used the old all-ones value, and global control must read zero afterwards. Behind these cases, a sweep runs every mix of old record class, corrected or uncorrected, action-required, nesting, unconditional flag and enable, and compares each outcome with an arithmetic model in the bench.

// File: rtl/mce_pkg.sv
package mce_pkg;
    localparam int DW        = 64;
    localparam int ST_VALID  = 63;
    localparam int ST_OVER   = 62;
    localparam int ST_UNCORR = 61;
    localparam int ST_ACTREQ = 55;
    localparam int GS_INPROG = 2;
    localparam int CAP_GCTLP = 8;

    typedef enum logic [2:0] {
        RC_NONE     = 3'd0,
        RC_REJECT   = 3'd1,
        RC_IGNORE   = 3'd2,
        RC_SUPPRESS = 3'd3,
        RC_LOGGED   = 3'd4,
        RC_OVERFLOW = 3'd5,
        RC_RESET    = 3'd6
    } resp_e;

    typedef struct packed {
        logic wr_addr;
        logic wr_misc;
        logic wr_status;
        logic wr_gstat;
        logic irq;
        logic rst;
    } action_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;
endpackage

// File: rtl/mce_judge.sv
module mce_judge
    import mce_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic [DW-1:0] cap,
    input  logic [DW-1:0] gctl,
    input  logic [DW-1:0] gstat,
    input  logic [DW-1:0] bank_ctl,
    input  logic [DW-1:0] bank_sts,
    input  logic [7:0]    inj_bank,
    input  logic [DW-1:0] inj_status,
    input  logic          inj_uncond,
    input  logic          mce_en,
    output resp_e         code,
    output action_t       act,
    output logic [DW-1:0] new_sts
);
    localparam logic [8:0] NB9 = 9'(NBANK);

    logic reject, old_valid, old_uc, nested, ctl_block;

    always_comb begin
        reject    = (cap == '0) || (inj_bank >= cap[7:0]) ||
                    ({1'b0, inj_bank} >= NB9) || !inj_status[ST_VALID];
        old_valid = bank_sts[ST_VALID];
        old_uc    = bank_sts[ST_UNCORR];
        nested    = gstat[GS_INPROG];
        ctl_block = (cap[CAP_GCTLP] && (gctl != '1)) || (bank_ctl != '1);
    end

    always_comb begin
        code    = RC_NONE;
        act     = '0;
        new_sts = inj_status;
        if (reject) begin
            code = RC_REJECT;
        end else if (!inj_uncond && !inj_status[ST_ACTREQ] && nested) begin
            code = RC_IGNORE;
        end else if (inj_status[ST_UNCORR]) begin
            if (ctl_block) begin
                code = RC_SUPPRESS;
            end else if (nested || !mce_en) begin
                code    = RC_RESET;
                act.rst = 1'b1;
            end else begin
                code          = RC_LOGGED;
                act.wr_addr   = 1'b1;
                act.wr_misc   = 1'b1;
                act.wr_status = 1'b1;
                act.wr_gstat  = 1'b1;
                act.irq       = 1'b1;
                new_sts[ST_OVER] = inj_status[ST_OVER] | old_valid;
            end
        end else if (!old_valid || !old_uc) begin
            code          = RC_LOGGED;
            act.wr_addr   = 1'b1;
            act.wr_misc   = 1'b1;
            act.wr_status = 1'b1;
            new_sts[ST_OVER] = inj_status[ST_OVER] | old_valid;
        end else begin
            code          = RC_OVERFLOW;
            act.wr_status = 1'b1;
            new_sts       = bank_sts;
            new_sts[ST_OVER] = 1'b1;
        end
    end
endmodule

// File: rtl/mce_bank_array.sv
module mce_bank_array
    import mce_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_we,
    input  logic [BW-1:0]             sw_bank,
    input  logic [1:0]                sw_sel,
    input  logic [DW-1:0]             sw_wdata,
    input  logic                      upd_en,
    input  logic [BW-1:0]             upd_bank,
    input  action_t                   upd_act,
    input  logic [DW-1:0]             upd_sts,
    input  logic [DW-1:0]             upd_addr,
    input  logic [DW-1:0]             upd_misc,
    output logic [NBANK-1:0][DW-1:0]  ctl_q,
    output logic [NBANK-1:0][DW-1:0]  sts_q,
    output logic [NBANK-1:0][DW-1:0]  addr_q,
    output logic [NBANK-1:0][DW-1:0]  misc_q
);
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic sw_hit, up_hit;
        assign sw_hit = sw_we  && (sw_bank  == BW'(g));
        assign up_hit = upd_en && (upd_bank == BW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q[g]  <= '1;
                sts_q[g]  <= '0;
                addr_q[g] <= '0;
                misc_q[g] <= '0;
            end else begin
                if (sw_hit) begin
                    unique case (sw_sel)
                        2'd0: ctl_q[g]  <= sw_wdata;
                        2'd1: sts_q[g]  <= sw_wdata;
                        2'd2: addr_q[g] <= sw_wdata;
                        2'd3: misc_q[g] <= sw_wdata;
                    endcase
                end
                // injection updates come last so they win a same-cycle clash
                if (up_hit) begin
                    if (upd_act.wr_status) sts_q[g]  <= upd_sts;
                    if (upd_act.wr_addr)   addr_q[g] <= upd_addr;
                    if (upd_act.wr_misc)   misc_q[g] <= upd_misc;
                end
            end
        end
    end
endmodule

// File: rtl/mce_bank_logger.sv
module mce_bank_logger
    import mce_pkg::*;
#(
    parameter int       NBANK        = 4,
    parameter int       AW           = 8,
    parameter bit       GCTL_PRESENT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mce_en,
    input  logic          inj_valid,
    input  logic [7:0]    inj_bank,
    input  logic [63:0]   inj_status,
    input  logic [63:0]   inj_gstatus,
    input  logic [63:0]   inj_addr,
    input  logic [63:0]   inj_misc,
    input  logic          inj_uncond,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [63:0]   reg_wdata,
    output logic [63:0]   reg_rdata,
    output logic          mc_irq,
    output logic          reset_req,
    output logic          resp_valid,
    output logic [2:0]    resp_code
);
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int IW = AW - 2;
    localparam logic [IW-1:0] NB_I = IW'(NBANK);
    localparam logic [8:0]    NB9  = 9'(NBANK);
    localparam logic [DW-1:0] CAP_RST = {55'd0, GCTL_PRESENT, 8'(NBANK)};

    logic [DW-1:0] cap_q, gctl_q, gstat_q;
    logic [NBANK-1:0][DW-1:0] ctl_q, sts_q, addr_q, misc_q;

    // software port decode
    logic [AW-1:0] bank_off;
    logic [IW-1:0] sw_idx;
    logic          sw_is_bank, sw_bank_ok, sw_bank_we;
    logic [BW-1:0] sw_bank;

    always_comb begin
        bank_off   = reg_addr - AW'(4);
        sw_idx     = bank_off[AW-1:2];
        sw_is_bank = (reg_addr >= AW'(4));
        sw_bank_ok = sw_is_bank && (sw_idx < NB_I);
        sw_bank    = sw_idx[BW-1:0];
        sw_bank_we = reg_we && sw_bank_ok;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(0))      reg_rdata = cap_q;
        else if (reg_addr == AW'(1)) reg_rdata = gctl_q;
        else if (reg_addr == AW'(2)) reg_rdata = gstat_q;
        else if (sw_bank_ok) begin
            unique case (bank_off[1:0])
                2'd0: reg_rdata = ctl_q[sw_bank];
                2'd1: reg_rdata = sts_q[sw_bank];
                2'd2: reg_rdata = addr_q[sw_bank];
                2'd3: reg_rdata = misc_q[sw_bank];
            endcase
        end
    end

    // injection decision
    logic          in_range;
    logic [BW-1:0] ib;
    resp_e         code;
    action_t       act;
    logic [DW-1:0] new_sts;

    always_comb begin
        in_range = ({1'b0, inj_bank} < NB9);
        ib       = in_range ? inj_bank[BW-1:0] : '0;
    end

    mce_judge #(.NBANK(NBANK)) u_judge (
        .cap        (cap_q),
        .gctl       (gctl_q),
        .gstat      (gstat_q),
        .bank_ctl   (ctl_q[ib]),
        .bank_sts   (sts_q[ib]),
        .inj_bank   (inj_bank),
        .inj_status (inj_status),
        .inj_uncond (inj_uncond),
        .mce_en     (mce_en),
        .code       (code),
        .act        (act),
        .new_sts    (new_sts)
    );

    mce_bank_array #(.NBANK(NBANK)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_bank_we),
        .sw_bank  (sw_bank),
        .sw_sel   (bank_off[1:0]),
        .sw_wdata (reg_wdata),
        .upd_en   (inj_valid),
        .upd_bank (ib),
        .upd_act  (act),
        .upd_sts  (new_sts),
        .upd_addr (inj_addr),
        .upd_misc (inj_misc),
        .ctl_q    (ctl_q),
        .sts_q    (sts_q),
        .addr_q   (addr_q),
        .misc_q   (misc_q)
    );

    // global registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q   <= CAP_RST;
            gctl_q  <= '1;
            gstat_q <= '0;
        end else begin
            if (reg_we && reg_addr == AW'(0)) cap_q   <= reg_wdata;
            if (reg_we && reg_addr == AW'(1)) gctl_q  <= reg_wdata;
            if (reg_we && reg_addr == AW'(2)) gstat_q <= reg_wdata;
            if (inj_valid && act.wr_gstat)    gstat_q <= inj_gstatus;
        end
    end

    // response state machine
    state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = inj_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = inj_valid ? ST_REPORT : ST_IDLE;
        endcase
    end

    resp_e code_q;
    logic  irq_q, rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= RC_NONE;
            irq_q  <= 1'b0;
            rst_q  <= 1'b0;
        end else begin
            code_q <= inj_valid ? code : RC_NONE;
            irq_q  <= inj_valid && act.irq;
            rst_q  <= inj_valid && act.rst;
        end
    end

    assign resp_valid = (state_q == ST_REPORT);
    assign resp_code  = code_q;
    assign mc_irq     = irq_q;
    assign reset_req  = rst_q;

    // R11
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |=> resp_valid);
    // R11
    resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_valid |=> !resp_valid && resp_code == 3'd0);
    // R11
    code_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_code != 3'd0);
    // R8
    irq_on_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_irq |-> resp_code == 3'd4);
    // R7
    reset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> resp_code == 3'd6 && !mc_irq);
    // R3
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && code == RC_REJECT && !reg_we) |=> $stable(gstat_q));
endmodule

// File: tb/mce_bank_logger_test.sv
`timescale 1ns/1ps
module mce_bank_logger_test;
    localparam logic [63:0] VB = 64'h1 << 63;
    localparam logic [63:0] OB = 64'h1 << 62;
    localparam logic [63:0] UB = 64'h1 << 61;
    localparam logic [63:0] AB = 64'h1 << 55;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mce_en = 1'b1, inj_valid = 1'b0, inj_uncond = 1'b0, reg_we = 1'b0;
    logic [7:0] inj_bank = '0;
    logic [63:0] inj_status = '0, inj_gstatus = '0, inj_addr = '0, inj_misc = '0;
    logic [7:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic mc_irq, reset_req, resp_valid;
    logic [2:0] resp_code;

    int n_chk = 0, n_fail = 0;
    logic [2:0] g_code;
    logic g_irq, g_rst, g_vld;

    always #2 clk = ~clk;

    mce_bank_logger uut (
        .clk(clk), .rst_n(rst_n), .mce_en(mce_en), .inj_valid(inj_valid),
        .inj_bank(inj_bank), .inj_status(inj_status), .inj_gstatus(inj_gstatus),
        .inj_addr(inj_addr), .inj_misc(inj_misc), .inj_uncond(inj_uncond),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mc_irq(mc_irq), .reset_req(reset_req),
        .resp_valid(resp_valid), .resp_code(resp_code)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic drive(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gs,
                         input logic [63:0] a, input logic [63:0] m, input logic u);
        inj_valid = 1'b1; inj_bank = b; inj_status = st; inj_gstatus = gs;
        inj_addr = a; inj_misc = m; inj_uncond = u;
    endtask

    task automatic grab();
        g_code = resp_code; g_irq = mc_irq; g_rst = reset_req; g_vld = resp_valid;
    endtask

    task automatic inject(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gs,
                          input logic [63:0] a, input logic [63:0] m, input logic u);
        @(negedge clk);
        drive(b, st, gs, a, m, u);
        @(negedge clk);
        inj_valid = 1'b0;
        grab();
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] d, old_s, exp_s, exp_a, exp_m, exp_g;
        int ec;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", {63'd0, mc_irq}, 64'd0);
        chk("R1 rst", {63'd0, reset_req}, 64'd0);
        chk("R1 resp_valid", {63'd0, resp_valid}, 64'd0);
        rst_n = 1'b1;
        rd(8'd0, d);  chk("R1 capability", d, 64'h104);
        rd(8'd1, d);  chk("R1 global control", d, '1);
        rd(8'd2, d);  chk("R1 global status", d, 64'd0);
        for (int b = 0; b < 4; b++) begin
            rd(8'(4 + 4 * b), d); chk("R1 bank control", d, '1);
            rd(8'(5 + 4 * b), d); chk("R1 bank status", d, 64'd0);
            rd(8'(6 + 4 * b), d); chk("R1 bank address", d, 64'd0);
            rd(8'(7 + 4 * b), d); chk("R1 bank misc", d, 64'd0);
        end
        chk("R1 code", {61'd0, resp_code}, 64'd0);

        // R2 register map
        wr(8'd19, 64'h1234_5678_9abc_def0);
        rd(8'd19, d); chk("R2 bank3 misc readback", d, 64'h1234_5678_9abc_def0);
        wr(8'd3, 64'hffff);
        rd(8'd3, d);  chk("R2 hole reads zero", d, 64'd0);
        wr(8'd20, 64'hffff);
        rd(8'd20, d); chk("R2 past last bank reads zero", d, 64'd0);
        wr(8'd19, 64'd0);

        // R3 rejections
        inject(8'd4, VB, 0, 1, 1, 0);
        chk("R3 bank beyond count", {61'd0, g_code}, 64'd1);
        inject(8'd0, 64'h5, 0, 1, 1, 0);
        chk("R3 status without valid", {61'd0, g_code}, 64'd1);
        rd(8'd5, d); chk("R3 bank0 status untouched", d, 64'd0);
        wr(8'd0, 64'h102);
        inject(8'd2, VB, 0, 1, 1, 0);
        chk("R3 bank at reduced count", {61'd0, g_code}, 64'd1);
        inject(8'd1, VB, 0, 64'h77, 1, 0);
        chk("R3 bank below reduced count", {61'd0, g_code}, 64'd4);
        wr(8'd0, 64'd0);
        inject(8'd0, VB, 0, 1, 1, 0);
        chk("R3 zero capability", {61'd0, g_code}, 64'd1);
        rd(8'd5, d); chk("R3 no write on zero capability", d, 64'd0);
        wr(8'd0, 64'h104);
        wr(8'd9, 64'd0);

        // R5 global control gating
        wr(8'd1, 64'd0);
        inject(8'd0, VB | UB, 64'h4, 64'h10, 64'h20, 0);
        chk("R5 suppressed by global control", {61'd0, g_code}, 64'd3);
        rd(8'd5, d); chk("R5 status untouched", d, 64'd0);
        wr(8'd0, 64'h004);
        inject(8'd0, VB | UB, 64'h4, 64'h10, 64'h20, 0);
        chk("R5 global control without capability flag", {61'd0, g_code}, 64'd4);
        chk("R8 interrupt pulse", {63'd0, g_irq}, 64'd1);
        @(negedge clk);
        chk("R8 interrupt is one cycle", {63'd0, mc_irq}, 64'd0);
        wr(8'd0, 64'h104); wr(8'd1, '1); wr(8'd2, 0); wr(8'd5, 0);

        // R6 bank control gating
        wr(8'd4, 64'd0);
        inject(8'd0, VB | UB, 64'h4, 1, 1, 0);
        chk("R6 uncorrected suppressed by bank control", {61'd0, g_code}, 64'd3);
        inject(8'd0, VB | 64'h9, 0, 64'h55, 1, 0);
        chk("R6 corrected not gated", {61'd0, g_code}, 64'd4);
        rd(8'd6, d); chk("R6 corrected address written", d, 64'h55);
        wr(8'd4, '1); wr(8'd5, 0);

        // R12 same-cycle software write and injection
        @(negedge clk);
        drive(8'd0, VB | UB, 64'h4, 64'hAAAA, 64'hBBBB, 0);
        reg_we = 1'b1; reg_addr = 8'd6; reg_wdata = 64'hDEAD;
        @(negedge clk);
        inj_valid = 1'b0; reg_we = 1'b0; grab();
        chk("R12 logged", {61'd0, g_code}, 64'd4);
        rd(8'd6, d); chk("R12 injection wins address", d, 64'hAAAA);
        wr(8'd2, 0); wr(8'd5, 0);
        @(negedge clk);
        drive(8'd1, VB | UB, 64'h4, 64'h1, 64'h2, 0);
        reg_we = 1'b1; reg_addr = 8'd1; reg_wdata = 64'd0;
        @(negedge clk);
        inj_valid = 1'b0; reg_we = 1'b0; grab();
        chk("R12 decision uses old global control", {61'd0, g_code}, 64'd4);
        rd(8'd1, d); chk("R12 software write still lands", d, 64'd0);
        wr(8'd1, '1); wr(8'd2, 0); wr(8'd9, 0);

        // R11 back-to-back injections
        @(negedge clk);
        drive(8'd7, VB, 0, 0, 0, 0);
        @(negedge clk);
        grab();
        drive(8'd2, VB | 64'h3, 0, 64'h9, 64'h9, 0);
        chk("R11 first response valid", {63'd0, g_vld}, 64'd1);
        chk("R11 first code", {61'd0, g_code}, 64'd1);
        @(negedge clk);
        inj_valid = 1'b0; grab();
        chk("R11 second response valid", {63'd0, g_vld}, 64'd1);
        chk("R11 second code", {61'd0, g_code}, 64'd4);
        @(negedge clk);
        chk("R11 response drops", {63'd0, resp_valid}, 64'd0);
        wr(8'd13, 0);

        // sweep: R4 R7 R8 R9 R10 on bank 1
        for (int oc = 0; oc < 3; oc++)
        for (int uc = 0; uc < 2; uc++)
        for (int ar = 0; ar < 2; ar++)
        for (int ne = 0; ne < 2; ne++)
        for (int un = 0; un < 2; un++)
        for (int en = 0; en < 2; en++) begin
            logic [63:0] st, gs0;
            old_s = (oc == 0) ? 64'h0 : (oc == 1) ? (VB | 64'h11) : (VB | UB | 64'h22);
            gs0   = (ne != 0) ? 64'h4 : 64'h0;
            st    = VB | (uc != 0 ? UB : 64'd0) | (ar != 0 ? AB : 64'd0) | 64'(oc * 32 + uc * 16 + ar * 8 + ne * 4 + un * 2 + en);
            wr(8'd2, gs0); wr(8'd9, old_s); wr(8'd10, 64'hA0A0); wr(8'd11, 64'hB0B0);
            mce_en = (en != 0);
            inject(8'd1, st, 64'h5, 64'h1000 + st[15:0], 64'h2000 + st[15:0], un != 0);
            exp_s = old_s; exp_a = 64'hA0A0; exp_m = 64'hB0B0; exp_g = gs0;
            if (un == 0 && ar == 0 && ne != 0) ec = 2;
            else if (uc != 0) begin
                if (ne != 0 || en == 0) ec = 6;
                else begin
                    ec = 4; exp_s = st | (old_s[63] ? OB : 64'd0);
                    exp_a = 64'h1000 + st[15:0]; exp_m = 64'h2000 + st[15:0]; exp_g = 64'h5;
                end
            end else if (oc != 2) begin
                ec = 4; exp_s = st | (old_s[63] ? OB : 64'd0);
                exp_a = 64'h1000 + st[15:0]; exp_m = 64'h2000 + st[15:0];
            end else begin
                ec = 5; exp_s = old_s | OB;
            end
            chk("R4/R7/R8/R9/R10 sweep code", {61'd0, g_code}, 64'(ec));
            chk("R8 sweep interrupt", {63'd0, g_irq}, (ec == 4 && uc != 0) ? 64'd1 : 64'd0);
            chk("R7 sweep reset request", {63'd0, g_rst}, (ec == 6) ? 64'd1 : 64'd0);
            rd(8'd9, d);  chk("R9 R10 sweep status", d, exp_s);
            rd(8'd10, d); chk("R9 sweep address", d, exp_a);
            rd(8'd11, d); chk("R9 sweep misc", d, exp_m);
            rd(8'd2, d);  chk("R4 R8 sweep global status", d, exp_g);
        end
        mce_en = 1'b1;
        finish_run();
    end
endmodule